// File: doc/BRIEF.md
# Bus Parity and Machine-Check Unit

This unit sits between a processor core and its system bus. It computes even parity per byte lane for every beat the core drives onto the write bus. It checks the per-lane parity that arrives on each of two independent read buses, each checker having its own enable. It also merges the address-error and data-error conditions that the bus reports into one sticky machine-check status register and an address capture register. Software reads both registers and clears status bits by writing ones.

Cache castouts are checked one whole line at a time. Each castout beat carries the parity held in the cache array. If any beat of the line disagrees with the parity the unit generates, one castout error is raised when the line's last beat goes out. On a read bus, an error on a beat of a cacheable line fill raises a per-bus inhibit. The inhibit stays up for every remaining beat of that line, so the cache and the register file discard the fill. A single level-sensitive machine-check request is raised while any status bit that software has enabled is set.

Top module: `bpar_mchk`

## Requirements
- R1: `wr_par[i]` equals the XOR of byte lane i of `wr_data` (even parity: the lane plus its parity bit hold an even number of ones), in the same cycle.
- R2: Each read bus has its own parity-check enable, written through `cfg_we`/`cfg_chk_en` (bit b enables bus b). Both enables are 0 after reset, and a disabled bus never reports a parity error.
- R3: A valid beat on an enabled bus whose `rd_par` differs from the per-lane even parity of its data sets status bit 2 (read parity error). This happens whether or not the beat belongs to a fill, that is, whether or not the data is consumed. A beat without `rd_valid` reports nothing.
- R4: A valid beat with `rd_aerr` sets status bit 0 (read address error). A valid beat with `rd_derr` sets status bit 1 (read data error).
- R5: `wr_aerr` high sets status bit 3 (write address error). `wr_err_n` low sets status bit 4 (write data error). Either one loads the capture register with the address of the most recent earlier write beat.
- R6: A castout line (`wr_valid` and `wr_castout` beats up to `wr_last`) with any beat whose `wr_src_par` differs from `wr_par` sets status bit 5 (castout parity error). It is set one edge after the last beat, never earlier, and the captured address is the line's first beat address. A clean line sets nothing.
- R7: The capture register loads only when an error arrives while the status (after any clear that cycle) is zero, and then holds. When errors coincide, the address is taken from the first source in this order: read bus 0, read bus 1, write error, castout.
- R8: Status bits are sticky and are cleared by `st_clr_we` with a one in `st_clr_mask`. A bit set and cleared in the same cycle stays set.
- R9: `fill_inhibit[b]` is high on a valid fill beat of bus b that carries an error, and on every later fill beat of the same line through `rd_last`. It is low for clean lines and for beats that are not part of a fill.
- R10: `mchk_req` is high exactly while the status ANDed with the `cfg_mc_en` mask (reset 0) is nonzero.
- R11: After reset the status, capture address, request and inhibits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the enable registers |
| cfg_chk_en | input | NBUS | Per-bus read parity check enable |
| cfg_mc_en | input | 6 | Status bits allowed to raise the request |
| rd_valid | input | NBUS | Read beat valid, per bus |
| rd_addr | input | NBUS x ADDR_W | Read beat address |
| rd_data | input | NBUS x DATA_W | Read beat data |
| rd_par | input | NBUS x DATA_W/8 | Read beat lane parity |
| rd_fill | input | NBUS | Beat belongs to a cacheable line fill |
| rd_last | input | NBUS | Last beat of the fill |
| rd_aerr | input | NBUS | Bus reports read address error |
| rd_derr | input | NBUS | Bus reports read data error |
| fill_inhibit | output | NBUS | Discard this fill beat |
| wr_valid | input | 1 | Write beat valid |
| wr_addr | input | ADDR_W | Write beat address |
| wr_data | input | DATA_W | Write beat data |
| wr_par | output | DATA_W/8 | Generated lane parity |
| wr_castout | input | 1 | Beat is part of a castout line |
| wr_last | input | 1 | Last castout beat |
| wr_src_par | input | DATA_W/8 | Parity stored with the castout beat |
| wr_aerr | input | 1 | Write address error |
| wr_err_n | input | 1 | Write data error, active low |
| st_clr_we | input | 1 | Write-one-to-clear strobe |
| st_clr_mask | input | 6 | Bits to clear |
| mcs_status | output | 6 | Sticky status |
| mcs_addr | output | ADDR_W | Captured error address |
| mchk_req | output | 1 | Machine-check request |

## Verification
Write parity and the fill inhibit are combinational, so they are due in the same cycle as the beat. The bench drives after a falling edge and samples one time step later, before the next rising edge. Status, capture address and request follow a read or write error one rising edge later. A castout error appears one rising edge after the line's last beat. For these registered results the bench samples at the falling edge after that rising edge, and it also samples after every earlier beat to show that nothing appears early.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    localparam int ST_W       = 6;
    localparam int ST_RD_ADDR = 0;
    localparam int ST_RD_DATA = 1;
    localparam int ST_RD_PAR  = 2;
    localparam int ST_WR_ADDR = 3;
    localparam int ST_WR_DATA = 4;
    localparam int ST_CO_PAR  = 5;

    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_CLEAN  = 2'd1,
        FL_POISON = 2'd2
    } fill_st_e;

    typedef enum logic [1:0] {
        CO_IDLE  = 2'd0,
        CO_CLEAN = 2'd1,
        CO_BAD   = 2'd2
    } co_st_e;
endpackage

// File: rtl/bpar_lane_par.sv
module bpar_lane_par #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] par
);
    localparam int LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign par[l] = ^data[l*8 +: 8];
    end
endmodule

// File: rtl/bpar_fill_fsm.sv
module bpar_fill_fsm
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_fill,
    input  logic beat_last,
    input  logic beat_err,
    output logic inhibit
);
    fill_st_e state, nxt;
    logic     fill_beat;

    assign fill_beat = beat_valid & beat_fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FL_IDLE: begin
                if (fill_beat && !beat_last)
                    nxt = beat_err ? FL_POISON : FL_CLEAN;
            end
            FL_CLEAN: begin
                if (fill_beat) begin
                    if (beat_last)     nxt = FL_IDLE;
                    else if (beat_err) nxt = FL_POISON;
                end
            end
            FL_POISON: begin
                if (fill_beat && beat_last) nxt = FL_IDLE;
            end
            default: nxt = FL_IDLE;
        endcase
    end

    always_comb begin
        inhibit = fill_beat & (beat_err | (state == FL_POISON));
    end
endmodule

// File: rtl/bpar_co_fsm.sv
module bpar_co_fsm
    import bpar_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              last,
    input  logic              bad,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] err_addr
);
    co_st_e            state, nxt;
    logic [ADDR_W-1:0] line_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= CO_IDLE;
            line_addr <= '0;
        end else begin
            state <= nxt;
            if (state == CO_IDLE && beat) line_addr <= addr;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CO_IDLE: begin
                if (beat && !last) nxt = bad ? CO_BAD : CO_CLEAN;
            end
            CO_CLEAN: begin
                if (beat) begin
                    if (last)     nxt = CO_IDLE;
                    else if (bad) nxt = CO_BAD;
                end
            end
            CO_BAD: begin
                if (beat && last) nxt = CO_IDLE;
            end
            default: nxt = CO_IDLE;
        endcase
    end

    always_comb begin
        err_pulse = beat & last & (bad | (state == CO_BAD));
        err_addr  = (state == CO_IDLE) ? addr : line_addr;
    end
endmodule

// File: rtl/bpar_mcsr.sv
module bpar_mcsr
    import bpar_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   set_vec,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_we,
    input  logic [ST_W-1:0]   clr_mask,
    output logic [ST_W-1:0]   status,
    output logic [ADDR_W-1:0] cap_addr
);
    logic [ST_W-1:0] kept, nxt;

    always_comb begin
        kept = clr_we ? (status & ~clr_mask) : status;
        nxt  = kept | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status   <= '0;
            cap_addr <= '0;
        end else begin
            status <= nxt;
            if (kept == '0 && set_vec != '0) cap_addr <= set_addr;
        end
    end
endmodule

// File: rtl/bpar_mchk.sv
module bpar_mchk
    import bpar_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int NBUS   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [NBUS-1:0]                    cfg_chk_en,
    input  logic [5:0]                         cfg_mc_en,
    input  logic [NBUS-1:0]                    rd_valid,
    input  logic [NBUS-1:0][ADDR_W-1:0]        rd_addr,
    input  logic [NBUS-1:0][DATA_W-1:0]        rd_data,
    input  logic [NBUS-1:0][DATA_W/8-1:0]      rd_par,
    input  logic [NBUS-1:0]                    rd_fill,
    input  logic [NBUS-1:0]                    rd_last,
    input  logic [NBUS-1:0]                    rd_aerr,
    input  logic [NBUS-1:0]                    rd_derr,
    output logic [NBUS-1:0]                    fill_inhibit,
    input  logic                               wr_valid,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [DATA_W/8-1:0]                wr_par,
    input  logic                               wr_castout,
    input  logic                               wr_last,
    input  logic [DATA_W/8-1:0]                wr_src_par,
    input  logic                               wr_aerr,
    input  logic                               wr_err_n,
    input  logic                               st_clr_we,
    input  logic [5:0]                         st_clr_mask,
    output logic [5:0]                         mcs_status,
    output logic [ADDR_W-1:0]                  mcs_addr,
    output logic                               mchk_req
);
    localparam int LANES = DATA_W / 8;

    logic [NBUS-1:0]   chk_en_q;
    logic [ST_W-1:0]   mc_en_q;
    logic [ADDR_W-1:0] last_wr_addr;
    logic [NBUS-1:0]   rd_perr, rd_bad;
    logic [ST_W-1:0]   set_vec;
    logic [ADDR_W-1:0] sel_addr;
    logic              co_beat, co_bad, co_pulse, wr_fault;
    logic [ADDR_W-1:0] co_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_en_q     <= '0;
            mc_en_q      <= '0;
            last_wr_addr <= '0;
        end else begin
            if (cfg_we) begin
                chk_en_q <= cfg_chk_en;
                mc_en_q  <= cfg_mc_en;
            end
            if (wr_valid) last_wr_addr <= wr_addr;
        end
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        logic [LANES-1:0] calc;

        bpar_lane_par #(.DATA_W(DATA_W)) u_par (
            .data (rd_data[b]),
            .par  (calc)
        );

        assign rd_perr[b] = rd_valid[b] & chk_en_q[b] & (calc != rd_par[b]);
        assign rd_bad[b]  = rd_perr[b] | (rd_valid[b] & (rd_aerr[b] | rd_derr[b]));

        bpar_fill_fsm u_fill (
            .clk        (clk),
            .rst_n      (rst_n),
            .beat_valid (rd_valid[b]),
            .beat_fill  (rd_fill[b]),
            .beat_last  (rd_last[b]),
            .beat_err   (rd_bad[b]),
            .inhibit    (fill_inhibit[b])
        );
    end

    bpar_lane_par #(.DATA_W(DATA_W)) u_wr_par (
        .data (wr_data),
        .par  (wr_par)
    );

    assign co_beat = wr_valid & wr_castout;
    assign co_bad  = co_beat & (wr_src_par != wr_par);

    bpar_co_fsm #(.ADDR_W(ADDR_W)) u_co (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (co_beat),
        .last      (wr_last),
        .bad       (co_bad),
        .addr      (wr_addr),
        .err_pulse (co_pulse),
        .err_addr  (co_addr)
    );

    assign wr_fault = wr_aerr | ~wr_err_n;

    always_comb begin
        set_vec             = '0;
        set_vec[ST_RD_ADDR] = |(rd_valid & rd_aerr);
        set_vec[ST_RD_DATA] = |(rd_valid & rd_derr);
        set_vec[ST_RD_PAR]  = |rd_perr;
        set_vec[ST_WR_ADDR] = wr_aerr;
        set_vec[ST_WR_DATA] = ~wr_err_n;
        set_vec[ST_CO_PAR]  = co_pulse;
    end

    always_comb begin
        sel_addr = co_addr;
        if (wr_fault) sel_addr = last_wr_addr;
        for (int b = NBUS - 1; b >= 0; b--) begin
            if (rd_bad[b]) sel_addr = rd_addr[b];
        end
    end

    bpar_mcsr #(.ADDR_W(ADDR_W)) u_mcsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .set_addr (sel_addr),
        .clr_we   (st_clr_we),
        .clr_mask (st_clr_mask),
        .status   (mcs_status),
        .cap_addr (mcs_addr)
    );

    assign mchk_req = |(mcs_status & mc_en_q);
endmodule

// File: rtl/bpar_mchk_chk.sv
module bpar_mchk_chk #(
    parameter int ADDR_W = 32,
    parameter int NBUS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        status,
    input logic [ADDR_W-1:0] cap,
    input logic              clr_we,
    input logic              req,
    input logic [NBUS-1:0]   inhibit,
    input logic [NBUS-1:0]   v,
    input logic [NBUS-1:0]   fill,
    input logic [NBUS-1:0]   aerr,
    input logic              werr_n
);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status)));

    a_r7_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((status != 6'd0) && !clr_we) |=> $stable(cap));

    a_r5_wr_data_err: assert property (@(posedge clk) disable iff (!rst_n)
        !werr_n |=> status[4]);

    a_r9_inhibit_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (v[0] && fill[0] && aerr[0]) |-> inhibit[0]);

    a_r10_req_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (status != 6'd0));
endmodule

bind bpar_mchk bpar_mchk_chk #(.ADDR_W(ADDR_W), .NBUS(NBUS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (mcs_status),
    .cap     (mcs_addr),
    .clr_we  (st_clr_we),
    .req     (mchk_req),
    .inhibit (fill_inhibit),
    .v       (rd_valid),
    .fill    (rd_fill),
    .aerr    (rd_aerr),
    .werr_n  (wr_err_n)
);

// File: tb/bpar_mchk_test.sv
module bpar_mchk_test;
    localparam int DW = 16;
    localparam int AW = 12;

    logic clk = 0, rst_n = 0;
    logic cfg_we; logic [1:0] cfg_chk_en; logic [5:0] cfg_mc_en;
    logic [1:0] rd_valid, rd_fill, rd_last, rd_aerr, rd_derr, fill_inhibit;
    logic [1:0][AW-1:0] rd_addr;
    logic [1:0][DW-1:0] rd_data;
    logic [1:0][1:0]    rd_par;
    logic wr_valid, wr_castout, wr_last, wr_aerr, wr_err_n;
    logic [AW-1:0] wr_addr; logic [DW-1:0] wr_data;
    logic [1:0] wr_par, wr_src_par;
    logic st_clr_we; logic [5:0] st_clr_mask, mcs_status;
    logic [AW-1:0] mcs_addr; logic mchk_req;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bpar_mchk #(.DATA_W(DW), .ADDR_W(AW), .NBUS(2)) uut (.*);

    function automatic logic [1:0] ep(input logic [15:0] d);
        logic [1:0] r = 2'b00;
        for (int l = 0; l < 2; l++)
            for (int i = 0; i < 8; i++) r[l] = r[l] ^ d[l*8+i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; cfg_chk_en = 0; cfg_mc_en = 0;
        rd_valid = 0; rd_fill = 0; rd_last = 0; rd_aerr = 0; rd_derr = 0;
        rd_addr = '0; rd_data = '0; rd_par = '0;
        wr_valid = 0; wr_castout = 0; wr_last = 0; wr_aerr = 0; wr_err_n = 1;
        wr_addr = 0; wr_data = 0; wr_src_par = 0;
        st_clr_we = 0; st_clr_mask = 0;
    endtask

    task automatic cfg(input logic [1:0] en, input logic [5:0] mc);
        cfg_we = 1; cfg_chk_en = en; cfg_mc_en = mc;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic clr(input logic [5:0] m);
        st_clr_we = 1; st_clr_mask = m;
        @(negedge clk); st_clr_we = 0; st_clr_mask = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 status", mcs_status, 0);
        chk("R11 addr", mcs_addr, 0);
        chk("R11 req", mchk_req, 0);
        chk("R11 inhibit", fill_inhibit, 0);

        // R1: exhaustive write parity
        for (int d = 0; d < 65536; d++) begin
            wr_data = d[15:0]; #1;
            chk("R1 wr_par", wr_par, ep(d[15:0]));
        end
        wr_data = 0;

        // R2: checks disabled after reset
        for (int b = 0; b < 2; b++) begin
            rd_valid[b] = 1; rd_data[b] = 16'h1234; rd_par[b] = ~ep(16'h1234);
            rd_addr[b] = 12'h100;
            @(negedge clk); idle(); @(negedge clk);
            chk("R2 disabled after reset", mcs_status, 0);
        end

        cfg(2'b11, 6'h3f);
        // R3: sweep data and parity on both buses, not a fill
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 4; k++)
                for (int p = 0; p < 4; p++) begin
                    logic [15:0] dv;
                    logic        bad;
                    dv = (k == 0) ? 16'h0000 : (k == 1) ? 16'h00ff : (k == 2) ? 16'h8001 : 16'ha5c3;
                    bad = (p[1:0] != ep(dv));
                    rd_valid[b] = 1; rd_data[b] = dv; rd_par[b] = p[1:0];
                    rd_addr[b] = AW'(12'h200 + b*16 + k*4 + p);
                    #1 chk("R3 no inhibit on non-fill", fill_inhibit, 0);
                    @(negedge clk); idle();
                    chk("R3 parity status", mcs_status, bad ? 6'h04 : 6'h00);
                    chk("R10 req follows status", mchk_req, bad);
                    if (bad) chk("R7 cap read addr", mcs_addr, 12'h200 + b*16 + k*4 + p);
                    clr(6'h3f);
                    chk("R8 cleared", mcs_status, 0);
                end

        // R3: no valid means nothing
        rd_data[0] = 16'h0001; rd_par[0] = 2'b00; rd_derr[0] = 1;
        @(negedge clk); idle();
        chk("R3 no valid no status", mcs_status, 0);

        // R2: only bus 0 enabled
        cfg(2'b01, 6'h3f);
        rd_valid[1] = 1; rd_data[1] = 16'h0100; rd_par[1] = 2'b00;
        @(negedge clk); idle();
        chk("R2 bus1 disabled", mcs_status, 0);
        rd_valid[0] = 1; rd_data[0] = 16'h0100; rd_par[0] = 2'b00; rd_addr[0] = 12'h0aa;
        @(negedge clk); idle();
        chk("R2 bus0 enabled", mcs_status, 6'h04);
        clr(6'h3f);
        cfg(2'b11, 6'h3f);

        // R4 / R7: first address held, priority
        rd_valid[0] = 1; rd_derr[0] = 1; rd_addr[0] = 12'h111;
        @(negedge clk); idle();
        chk("R4 read data err", mcs_status, 6'h02);
        rd_valid[1] = 1; rd_aerr[1] = 1; rd_addr[1] = 12'h222;
        @(negedge clk); idle();
        chk("R4 read addr err", mcs_status, 6'h03);
        chk("R7 first address held", mcs_addr, 12'h111);
        clr(6'h01);
        chk("R8 partial clear", mcs_status, 6'h02);
        chk("R7 cap kept", mcs_addr, 12'h111);
        st_clr_we = 1; st_clr_mask = 6'h02;
        rd_valid[0] = 1; rd_derr[0] = 1; rd_addr[0] = 12'h333;
        @(negedge clk); idle();
        chk("R8 set beats clear", mcs_status, 6'h02);
        chk("R7 recapture after clear", mcs_addr, 12'h333);
        clr(6'h3f);
        rd_valid = 2'b11; rd_aerr = 2'b11; rd_addr[0] = 12'h444; rd_addr[1] = 12'h555;
        @(negedge clk); idle();
        chk("R7 bus0 priority", mcs_addr, 12'h444);
        clr(6'h3f);

        // R5: write errors
        wr_valid = 1; wr_addr = 12'h6a0; wr_data = 16'h55aa;
        @(negedge clk); idle();
        wr_err_n = 0;
        @(negedge clk); idle();
        chk("R5 write data err", mcs_status, 6'h10);
        chk("R5 write addr capture", mcs_addr, 12'h6a0);
        clr(6'h3f);
        wr_aerr = 1;
        @(negedge clk); idle();
        chk("R5 write addr err", mcs_status, 6'h08);
        chk("R5 write addr capture 2", mcs_addr, 12'h6a0);
        clr(6'h3f);
        wr_aerr = 1; rd_valid[1] = 1; rd_derr[1] = 1; rd_addr[1] = 12'h777;
        @(negedge clk); idle();
        chk("R7 read before write", mcs_addr, 12'h777);
        clr(6'h3f);

        // R6: castout lines, bad beat k (k==4 clean)
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] dv;
                dv = 16'h1357 + 16'(i * 16'h1111);
                wr_valid = 1; wr_castout = 1; wr_last = (i == 3);
                wr_addr = AW'(12'h800 + k*32 + i*4); wr_data = dv;
                wr_src_par = (i == k) ? ~ep(dv) : ep(dv);
                @(negedge clk); idle();
                if (i < 3) chk("R6 not before last", mcs_status, 0);
            end
            chk("R6 line status", mcs_status, (k < 4) ? 6'h20 : 6'h00);
            if (k < 4) chk("R6 line address", mcs_addr, 12'h800 + k*32);
            clr(6'h3f);
        end
        wr_valid = 1; wr_castout = 1; wr_last = 1; wr_addr = 12'h9f0;
        wr_data = 16'h0f01; wr_src_par = ~ep(16'h0f01);
        @(negedge clk); idle();
        chk("R6 single beat line", mcs_status, 6'h20);
        chk("R6 single beat addr", mcs_addr, 12'h9f0);
        clr(6'h3f);

        // R9: fill inhibit, error on beat k (k==4 clean)
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] dv;
                dv = 16'h0102 * 16'(i + 1);
                rd_valid[0] = 1; rd_fill[0] = 1; rd_last[0] = (i == 3);
                rd_data[0] = dv; rd_par[0] = (i == k) ? ~ep(dv) : ep(dv);
                #1 chk("R9 fill inhibit", fill_inhibit, {1'b0, (i >= k)});
                @(negedge clk); idle();
            end
            clr(6'h3f);
        end

        // R10: request mask
        cfg(2'b11, 6'h10);
        rd_valid[0] = 1; rd_aerr[0] = 1;
        @(negedge clk); idle();
        chk("R10 masked", mchk_req, 0);
        wr_err_n = 0;
        @(negedge clk); idle();
        chk("R10 unmasked", mchk_req, 1);
        clr(6'h3f);
        chk("R10 drops after clear", mchk_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule